// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit virtual address into a 16-bit physical address through a four-entry segment table. The two top bits of the virtual address choose one table entry. The lower twelve bits are an offset into that segment. Each entry holds a physical base, a length, a present flag, and separate read and write permissions. A request that passes every check gets the physical address base plus offset. A request that fails gets a fault code, which the surrounding control logic can use to handle copy-on-write, demand growth or a bad reference.

Requests come in on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. The result of an accepted request appears on the following cycle. While the consumer holds `rsp_ready` low, the result stays frozen and no new request is taken: `req_ready` follows the output register's emptiness or the consumer's readiness in the same cycle, so back-pressure reaches the producer with no extra buffering. The table is written one entry per cycle through a plain write strobe. A context switch rewrites all four entries in four cycles.

Top module: `segmap_unit`

## Requirements
- R1: After reset `rsp_valid` is 0 and all four entries are not present, so any request returns fault code 2'b01.
- R2: Virtual address bits [13:12] select the entry and bits [11:0] are the offset. A passing request returns `rsp_paddr` = (base + offset) mod 2^16 with fault code 2'b00.
- R3: A request to an entry whose present flag is 0 returns fault code 2'b01, whatever its offset or direction.
- R4: A request to a present entry whose offset is greater than or equal to the entry length (13-bit length, 0 to 0x1000) returns fault code 2'b10.
- R5: A request within bounds returns fault code 2'b11 if it is a write (`req_write`=1) to an entry without write permission, or a read to an entry without read permission. When more than one fault applies, 2'b01 takes priority over 2'b10, and 2'b10 over 2'b11.
- R6: Every response with a non-zero fault code carries `rsp_paddr` = 0.
- R7: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request gives `rsp_valid`=1 one cycle later. While `rsp_valid`=1 and `rsp_ready`=0, the response values do not change.
- R8: With `tbl_we`=1, entry `tbl_sel` takes the new fields at the clock edge. A request accepted at that same edge is checked against the previous content of the entry.
- R9: A table write changes only the selected entry. Translations through the other entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_sel | input | 2 | Entry to write |
| tbl_base | input | 16 | Physical base of the entry |
| tbl_len | input | 13 | Segment length in bytes |
| tbl_present | input | 1 | Entry present flag |
| tbl_can_rd | input | 1 | Read permission |
| tbl_can_wr | input | 1 | Write permission |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 14 | Virtual address: entry index and offset |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer ready for the response |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 bound, 11 permission |

## Verification
A translation is due on the first rising edge after the edge that accepts the request. The bench drives each request at a falling edge and reads the response at the next falling edge, so exactly one register separates stimulus from observation. A table write takes effect at the edge where it is strobed. The same-cycle test therefore checks the old mapping at the next falling edge and the new mapping on the request after that. Under back-pressure the bench samples on two successive falling edges to confirm that the held response has not moved. It then checks that the queued request comes out one edge after `rsp_ready` rises.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  localparam int SEG_W = 2;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int LEN_W = OFF_W + 1;
  localparam int VA_W  = SEG_W + OFF_W;
  localparam int NSEG  = 1 << SEG_W;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_NOSEG = 2'b01,
    FLT_BOUND = 2'b10,
    FLT_PERM  = 2'b11
  } fault_e;

  typedef struct packed {
    logic             present;
    logic             can_rd;
    logic             can_wr;
    logic [LEN_W-1:0] len;
    logic [PA_W-1:0]  base;
  } seg_ent_t;
endpackage

// File: rtl/segmap_table.sv
module segmap_table
  import segmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_sel,
  input  seg_ent_t         wr_ent,
  input  logic [SEG_W-1:0] rd_sel,
  output seg_ent_t         rd_ent
);
  seg_ent_t ents [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (wr_en && (wr_sel == SEG_W'(i))) begin
        ents[i] <= wr_ent;
      end
    end
  end

  assign rd_ent = ents[rd_sel];
endmodule

// File: rtl/segmap_check.sv
module segmap_check
  import segmap_pkg::*;
(
  input  seg_ent_t         ent,
  input  logic [OFF_W-1:0] off,
  input  logic             is_wr,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);
  logic in_bound;
  logic allowed;

  always_comb begin
    in_bound = ({1'b0, off} < ent.len);
    allowed  = is_wr ? ent.can_wr : ent.can_rd;
    if (!ent.present)   fault = FLT_NOSEG;
    else if (!in_bound) fault = FLT_BOUND;
    else if (!allowed)  fault = FLT_PERM;
    else                fault = FLT_NONE;
    paddr = (fault == FLT_NONE) ? (ent.base + PA_W'(off)) : '0;
  end
endmodule

// File: rtl/segmap_outreg.sv
module segmap_outreg
  import segmap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  fault_e          in_fault,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic [1:0]      out_fault
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= FLT_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_paddr <= in_paddr;
        out_fault <= in_fault;
      end
    end
  end
endmodule

// File: rtl/segmap_unit.sv
module segmap_unit
  import segmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_sel,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [LEN_W-1:0] tbl_len,
  input  logic             tbl_present,
  input  logic             tbl_can_rd,
  input  logic             tbl_can_wr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  seg_ent_t         new_ent;
  seg_ent_t         cur_ent;
  logic [SEG_W-1:0] seg_idx;
  logic [OFF_W-1:0] seg_off;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_paddr;

  assign seg_idx = req_vaddr[VA_W-1 -: SEG_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  always_comb begin
    new_ent.present = tbl_present;
    new_ent.can_rd  = tbl_can_rd;
    new_ent.can_wr  = tbl_can_wr;
    new_ent.len     = tbl_len;
    new_ent.base    = tbl_base;
  end

  segmap_table table_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we),
    .wr_sel (tbl_sel),
    .wr_ent (new_ent),
    .rd_sel (seg_idx),
    .rd_ent (cur_ent)
  );

  segmap_check check_i (
    .ent   (cur_ent),
    .off   (seg_off),
    .is_wr (req_write),
    .fault (chk_fault),
    .paddr (chk_paddr)
  );

  segmap_outreg outreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_paddr  (chk_paddr),
    .in_fault  (chk_fault),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_paddr (rsp_paddr),
    .out_fault (rsp_fault)
  );
endmodule

// File: rtl/segmap_unit_chk.sv
module segmap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_paddr,
  input logic [1:0]  rsp_fault
);
  a_r7_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != 2'b00)) |-> (rsp_paddr == 16'h0));

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rsp_valid)) |-> $past(req_valid && req_ready));
endmodule

bind segmap_unit segmap_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault)
);

// File: tb/segmap_unit_tb_top.sv
module segmap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [15:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic        tbl_present = 1'b0;
  logic        tbl_can_rd = 1'b0;
  logic        tbl_can_wr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_base [4];
  logic [12:0] m_len  [4];
  logic        m_pres [4];
  logic        m_rd   [4];
  logic        m_wr   [4];

  always #5 clk = ~clk;

  segmap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .tbl_present(tbl_present),
    .tbl_can_rd(tbl_can_rd), .tbl_can_wr(tbl_can_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  function automatic logic [1:0] exp_fault(input logic [1:0] s, input logic [11:0] o, input logic w);
    if (!m_pres[s]) return 2'b01;
    if ({1'b0, o} >= m_len[s]) return 2'b10;
    if (w ? !m_wr[s] : !m_rd[s]) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [15:0] exp_pa(input logic [1:0] s, input logic [11:0] o, input logic w);
    if (exp_fault(s, o, w) != 2'b00) return 16'h0;
    return m_base[s] + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] b, input logic [12:0] l,
                      input logic p, input logic r, input logic w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = s; tbl_base = b; tbl_len = l;
    tbl_present = p; tbl_can_rd = r; tbl_can_wr = w;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[s] = b; m_len[s] = l; m_pres[s] = p; m_rd[s] = r; m_wr[s] = w;
  endtask

  task automatic send(input logic [1:0] s, input logic [11:0] o, input logic w, input string tag);
    logic [1:0]  ef;
    logic [15:0] ep;
    ef = exp_fault(s, o, w);
    ep = exp_pa(s, o, w);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {s, o}; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R7 valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_fault == ef, {tag, " fault"}, 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr == ep, {tag, " paddr"}, 32'(rsp_paddr), 32'(ep));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_pres[i] = 1'b0; m_rd[i] = 1'b0; m_wr[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R7 ready after reset", 32'(req_ready), 32'd1);
    send(2'd0, 12'h000, 1'b0, "R1 empty table");
    send(2'd3, 12'h7ff, 1'b1, "R1 empty table write");

    // context switch: reference table
    load(2'd0, 16'h4000, 13'h0700, 1'b1, 1'b1, 1'b0);
    load(2'd1, 16'h0000, 13'h0500, 1'b1, 1'b1, 1'b1);
    load(2'd2, 16'h0000, 13'h0000, 1'b0, 1'b1, 1'b1);
    load(2'd3, 16'h2000, 13'h1000, 1'b1, 1'b1, 1'b1);

    send(2'd0, 12'h240, 1'b0, "R2 code 0x240");
    send(2'd0, 12'h6ff, 1'b0, "R4 last in-bound");
    send(2'd0, 12'h700, 1'b0, "R4 first out-of-bound");
    send(2'd0, 12'h240, 1'b1, "R5 write read-only");
    send(2'd0, 12'h800, 1'b1, "R5 bound beats perm");
    send(2'd2, 12'h000, 1'b0, "R3 absent read");
    send(2'd2, 12'hfff, 1'b1, "R3 absent write");
    send(2'd1, 12'h4ff, 1'b1, "R2 data write");
    send(2'd1, 12'h500, 1'b0, "R4 data limit R6");
    send(2'd3, 12'hfff, 1'b0, "R2 stack full length");

    // write-only entry, then others untouched
    load(2'd2, 16'h9000, 13'h0100, 1'b1, 1'b0, 1'b1);
    send(2'd2, 12'h010, 1'b0, "R5 read without read perm");
    send(2'd2, 12'h010, 1'b1, "R5 write allowed");
    send(2'd0, 12'h240, 1'b0, "R9 code unchanged");
    send(2'd3, 12'h123, 1'b0, "R9 stack unchanged");

    // R8 same-cycle write and request
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'd1; tbl_base = 16'h8000; tbl_len = 13'h0500;
    tbl_present = 1'b1; tbl_can_rd = 1'b1; tbl_can_wr = 1'b1;
    req_valid = 1'b1; req_vaddr = {2'd1, 12'h010}; req_write = 1'b0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk(rsp_paddr == 16'h0010, "R8 old entry used", 32'(rsp_paddr), 32'h0010);
    m_base[1] = 16'h8000;
    send(2'd1, 12'h010, 1'b0, "R8 new entry used");

    // R7 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = {2'd3, 12'h123}; req_write = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 16'h2123, "R7 first result", 32'(rsp_paddr), 32'h2123);
    chk(req_ready == 1'b0, "R7 ready low in stall", 32'(req_ready), 32'd0);
    req_vaddr = {2'd0, 12'h001};
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 16'h2123, "R7 held in stall", 32'(rsp_paddr), 32'h2123);
    chk(req_ready == 1'b0, "R7 still stalled", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == 16'h4001, "R7 queued result", 32'(rsp_paddr), 32'h4001);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 drained", 32'(rsp_valid), 32'd0);

    // constrained random
    void'($urandom(32'd20240927));
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(15, 0) == 0) begin
        load(2'($urandom_range(3, 0)), 16'($urandom()), 13'($urandom_range(4096, 0)),
             1'($urandom_range(3, 0) != 0), 1'($urandom()), 1'($urandom()));
      end else begin
        send(2'($urandom_range(3, 0)), 12'($urandom()), 1'($urandom()), "R2 R4 R5 random");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule